// File: doc/BRIEF.md
# DMA Termination Strobe and Interrupt Gate

This block is the per-channel control unit that decides when a DMA channel shows its transfer-end strobe and its request-acknowledge strobe, and whether the end of a block raises an interrupt request. Each of the three channels has one control word. Software writes the word through a simple register port and can read it back. The word holds two pairs of phase-select bits, two interrupt enables and a small status field that records termination.

The surrounding controller reports, for each channel, when the current bus access is the source-address access and when it is the destination-address access. It also reports whether the transfer is the last of the block and when the channel ends normally or with an error. The strobes come straight from these indicators through the enables, with no register on the way. The interrupt requests are level outputs and follow the status flags and the enables.

Control word layout: bits [2:0] status (bit 0 normal end, bit 1 error end, bit 2 a termination event arrived while a flag was already set). Bit 3 is acknowledge on source and bit 4 acknowledge on destination. Bit 5 is end strobe on source and bit 6 end strobe on destination. Bit 9 is the end-interrupt enable and bit 10 the error-interrupt enable. All other bits are reserved.

Top module: `dma_strb_ctrl`

## Requirements
- R1: After reset every enable bit and every status bit of every channel is 0, and all strobe and interrupt outputs are low.
- R2: A write to channel c (reg_we=1, reg_ch=c) loads bits 3, 4, 5, 6, 9 and 10 from reg_wdata. reg_rdata shows the selected channel's word in the same cycle that reg_ch changes.
- R3: Bits 7, 8 and 11 to 15 always read 0, and writes to them have no effect.
- R4: end_pulse[c] is high in a cycle exactly when last_xfer[c] is high and either src_ph[c] and bit 5 are both set, or dst_ph[c] and bit 6 are both set. It is asserted in the same cycle as the phase indicator.
- R5: ack_pulse[c] is high in a cycle exactly when either src_ph[c] and bit 3 are both set, or dst_ph[c] and bit 4 are both set, whatever the value of last_xfer.
- R6: A done_evt[c] pulse sets status bit 0 and an err_evt[c] pulse sets status bit 1, on the next clock edge. A termination event that arrives while bit 0 or bit 1 is already set also sets bit 2.
- R7: The status field is cleared only by a write whose bits [2:0] are 000. A write with a non-zero value there leaves the field unchanged, while the enable bits of that write still load.
- R8: end_irq[c] is high while status bit 0 and enable bit 9 are both set. It falls once either one is cleared.
- R9: err_irq[c] is high while status bit 1 and enable bit 10 are both set. It falls once either one is cleared.
- R10: Channels are independent. A write changes only the channel selected by reg_ch. A reg_ch value of 3 or more writes nothing and reads 0.
- R11: If a termination event and a clearing write reach the same channel in the same cycle, the event's flag survives and bit 2 is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel select for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected channel |
| src_ph | input | 3 | Source-address access in progress, per channel |
| dst_ph | input | 3 | Destination-address access in progress, per channel |
| last_xfer | input | 3 | Current transfer is the final one of the block |
| done_evt | input | 3 | Normal termination event pulse |
| err_evt | input | 3 | Abnormal termination event pulse |
| end_pulse | output | 3 | Transfer-end strobe |
| ack_pulse | output | 3 | Request-acknowledge strobe |
| end_irq | output | 3 | Normal-end interrupt request |
| err_irq | output | 3 | Error-end interrupt request |

## Verification
The bench targets the following corner cases:
- A write of all ones. It catches a design that stores reserved bits or that treats any write as a clear of the status field.
- A clearing write in the same cycle as a termination event. A design with the wrong priority loses the event and with it the interrupt.
- End strobes with last_xfer low. They show whether a design confuses the end strobe with the acknowledge strobe.
- Swapped source and destination select bits. Under random phase patterns these would strobe on the wrong access.
- Writes to an out-of-range channel, and events on one channel while another is read. A decoder that aliases channels fails these.

// File: rtl/dma_strb_pkg.sv
package dma_strb_pkg;
  localparam int REG_W   = 16;
  localparam int ST_LSB  = 0;
  localparam int ST_W    = 3;
  localparam int ACK_SRC = 3;
  localparam int ACK_DST = 4;
  localparam int END_SRC = 5;
  localparam int END_DST = 6;
  localparam int END_IE  = 9;
  localparam int ERR_IE  = 10;

  localparam logic [REG_W-1:0] ST_MASK  = REG_W'(((1 << ST_W) - 1) << ST_LSB);
  localparam logic [REG_W-1:0] EN_MASK  = REG_W'((1 << ACK_SRC) | (1 << ACK_DST) | (1 << END_SRC) |
                                                  (1 << END_DST) | (1 << END_IE) | (1 << ERR_IE));
  localparam logic [REG_W-1:0] RSV_MASK = ~(ST_MASK | EN_MASK);

  typedef struct packed {
    logic err_ie;
    logic end_ie;
    logic end_dst;
    logic end_src;
    logic ack_dst;
    logic ack_src;
  } chan_en_t;

  function automatic chan_en_t en_from_word(logic [REG_W-1:0] w);
    chan_en_t e;
    e.ack_src = w[ACK_SRC];
    e.ack_dst = w[ACK_DST];
    e.end_src = w[END_SRC];
    e.end_dst = w[END_DST];
    e.end_ie  = w[END_IE];
    e.err_ie  = w[ERR_IE];
    return e;
  endfunction

  function automatic logic [REG_W-1:0] word_from(chan_en_t e, logic [ST_W-1:0] st);
    logic [REG_W-1:0] w;
    w = '0;
    w[ACK_SRC] = e.ack_src;
    w[ACK_DST] = e.ack_dst;
    w[END_SRC] = e.end_src;
    w[END_DST] = e.end_dst;
    w[END_IE]  = e.end_ie;
    w[ERR_IE]  = e.err_ie;
    w[ST_LSB +: ST_W] = st;
    return w;
  endfunction

  // strobe is live when a selected phase is active
  function automatic logic phase_gate(logic sel_src, logic sel_dst, logic src, logic dst);
    return (sel_src & src) | (sel_dst & dst);
  endfunction

  // clear first, then merge new events; bit 2 marks an event on top of a pending flag
  function automatic logic [ST_W-1:0] stat_next(logic [ST_W-1:0] cur, logic clr,
                                                logic done, logic err);
    logic [ST_W-1:0] base;
    logic ovf;
    base = clr ? '0 : cur;
    ovf  = (done | err) & (base[0] | base[1]);
    return base | {ovf, err, done};
  endfunction
endpackage

// File: rtl/dma_strb_chreg.sv
module dma_strb_chreg
  import dma_strb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             done_evt,
  input  logic             err_evt,
  output chan_en_t         en,
  output logic [ST_W-1:0]  stat,
  output logic             clr_hit
);
  assign clr_hit = wr && (wdata[ST_LSB +: ST_W] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= '0;
      stat <= '0;
    end else begin
      if (wr) en <= en_from_word(wdata);
      stat <= stat_next(stat, clr_hit, done_evt, err_evt);
    end
  end
endmodule

// File: rtl/dma_strb_gate.sv
module dma_strb_gate
  import dma_strb_pkg::*;
(
  input  chan_en_t en,
  input  logic     done_f,
  input  logic     err_f,
  input  logic     src,
  input  logic     dst,
  input  logic     last,
  output logic     end_p,
  output logic     ack_p,
  output logic     end_rq,
  output logic     err_rq
);
  assign end_p  = last & phase_gate(en.end_src, en.end_dst, src, dst);
  assign ack_p  = phase_gate(en.ack_src, en.ack_dst, src, dst);
  assign end_rq = done_f & en.end_ie;
  assign err_rq = err_f & en.err_ie;
endmodule

// File: rtl/dma_strb_ctrl.sv
module dma_strb_ctrl
  import dma_strb_pkg::*;
#(
  parameter  int NCH  = 3,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH + 1) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [CH_W-1:0]  reg_ch,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NCH-1:0]   src_ph,
  input  logic [NCH-1:0]   dst_ph,
  input  logic [NCH-1:0]   last_xfer,
  input  logic [NCH-1:0]   done_evt,
  input  logic [NCH-1:0]   err_evt,
  output logic [NCH-1:0]   end_pulse,
  output logic [NCH-1:0]   ack_pulse,
  output logic [NCH-1:0]   end_irq,
  output logic [NCH-1:0]   err_irq
);
  chan_en_t                  en_w [NCH];
  logic [NCH-1:0][ST_W-1:0]  stat_w;
  logic [NCH-1:0]            clr_w;
  logic [NCH-1:0]            wr_sel;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wr_sel[c] = reg_we && (reg_ch == CH_W'(c));

    dma_strb_chreg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_sel[c]),
      .wdata    (reg_wdata),
      .done_evt (done_evt[c]),
      .err_evt  (err_evt[c]),
      .en       (en_w[c]),
      .stat     (stat_w[c]),
      .clr_hit  (clr_w[c])
    );

    dma_strb_gate u_gate (
      .en     (en_w[c]),
      .done_f (stat_w[c][0]),
      .err_f  (stat_w[c][1]),
      .src    (src_ph[c]),
      .dst    (dst_ph[c]),
      .last   (last_xfer[c]),
      .end_p  (end_pulse[c]),
      .ack_p  (ack_pulse[c]),
      .end_rq (end_irq[c]),
      .err_rq (err_irq[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++)
      if (reg_ch == CH_W'(c)) reg_rdata = word_from(en_w[c], stat_w[c]);
  end
endmodule

// File: rtl/dma_strb_chk.sv
module dma_strb_chk
  import dma_strb_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [REG_W-1:0]         reg_rdata,
  input logic [NCH-1:0]           src_ph,
  input logic [NCH-1:0]           dst_ph,
  input logic [NCH-1:0]           last_xfer,
  input logic [NCH-1:0]           done_evt,
  input logic [NCH-1:0]           err_evt,
  input logic [NCH-1:0]           end_pulse,
  input logic [NCH-1:0]           ack_pulse,
  input logic [NCH-1:0]           end_irq,
  input logic [NCH-1:0]           err_irq,
  input logic [NCH-1:0][ST_W-1:0] stat_w,
  input logic [NCH-1:0]           clr_w
);
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & RSV_MASK) == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    p_end_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      end_pulse[c] |-> (last_xfer[c] && (src_ph[c] || dst_ph[c])));
    p_ack_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_pulse[c] |-> (src_ph[c] || dst_ph[c]));
    p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt[c] |=> stat_w[c][0]);
    p_err_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt[c] |=> stat_w[c][1]);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_w[c] |=> ((stat_w[c] & $past(stat_w[c])) == $past(stat_w[c])));
    p_end_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      end_irq[c] |-> stat_w[c][0]);
    p_err_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq[c] |-> stat_w[c][1]);
  end
endmodule

bind dma_strb_ctrl dma_strb_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rdata (reg_rdata),
  .src_ph    (src_ph),
  .dst_ph    (dst_ph),
  .last_xfer (last_xfer),
  .done_evt  (done_evt),
  .err_evt   (err_evt),
  .end_pulse (end_pulse),
  .ack_pulse (ack_pulse),
  .end_irq   (end_irq),
  .err_irq   (err_irq),
  .stat_w    (stat_w),
  .clr_w     (clr_w)
);

// File: tb/sim_dma_strb_ctrl.sv
`timescale 1ns/1ps
module sim_dma_strb_ctrl;
  localparam int NCH = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_ch = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [2:0]  src_ph = 0, dst_ph = 0, last_xfer = 0, done_evt = 0, err_evt = 0;
  logic [2:0]  end_pulse, ack_pulse, end_irq, err_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] m_en [3];
  logic [2:0]  m_st [3];

  always #5 clk = ~clk;

  dma_strb_ctrl #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_ph(src_ph), .dst_ph(dst_ph), .last_xfer(last_xfer),
    .done_evt(done_evt), .err_evt(err_evt),
    .end_pulse(end_pulse), .ack_pulse(ack_pulse),
    .end_irq(end_irq), .err_irq(err_irq)
  );

  localparam logic [15:0] EN_BITS = 16'h0678;

  function automatic logic [15:0] f_word(int c);
    return (c < 3) ? ((m_en[c] & EN_BITS) | {13'd0, m_st[c]}) : 16'h0;
  endfunction
  function automatic logic f_end(int c);
    return last_xfer[c] & ((src_ph[c] & m_en[c][5]) | (dst_ph[c] & m_en[c][6]));
  endfunction
  function automatic logic f_ack(int c);
    return (src_ph[c] & m_en[c][3]) | (dst_ph[c] & m_en[c][4]);
  endfunction
  function automatic logic f_eirq(int c);
    return m_st[c][0] & m_en[c][9];
  endfunction
  function automatic logic f_xirq(int c);
    return m_st[c][1] & m_en[c][10];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < 3; c++) begin
      logic wr, clr, ev, ovf;
      logic [2:0] base;
      wr   = reg_we && (int'(reg_ch) == c);
      clr  = wr && (reg_wdata[2:0] == 3'b000);
      base = clr ? 3'b000 : m_st[c];
      ev   = done_evt[c] | err_evt[c];
      ovf  = ev & (base[0] | base[1]);
      m_st[c] = base | {ovf, err_evt[c], done_evt[c]};
      if (wr) m_en[c] = reg_wdata & EN_BITS;
    end
  endtask

  // compare combinational outputs, then advance one clock
  task automatic cycle();
    #1;
    chk("R2/R3/R10 rdata", 32'(reg_rdata), 32'(f_word(int'(reg_ch))));
    for (int c = 0; c < 3; c++) begin
      chk("R4 end_pulse", 32'(end_pulse[c]), 32'(f_end(c)));
      chk("R5 ack_pulse", 32'(ack_pulse[c]), 32'(f_ack(c)));
      chk("R8 end_irq",   32'(end_irq[c]),   32'(f_eirq(c)));
      chk("R9 err_irq",   32'(err_irq[c]),   32'(f_xirq(c)));
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    reg_we = 0; src_ph = 0; dst_ph = 0; last_xfer = 0; done_evt = 0; err_evt = 0;
  endtask

  task automatic wr(int c, logic [15:0] d);
    idle(); reg_we = 1; reg_ch = 2'(c); reg_wdata = d; cycle(); idle();
  endtask

  task automatic rd_chk(string tag, int c, logic [15:0] exp);
    idle(); reg_ch = 2'(c); #1;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 3; c++) begin m_en[c] = 0; m_st[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int c = 0; c < 3; c++) rd_chk("R1 reset word", c, 16'h0000);
    chk("R1 outputs", 32'({end_pulse, ack_pulse, end_irq, err_irq}), 32'h0);
    // R3, R7: all ones, status stays 0 since field is non-zero
    wr(1, 16'hFFFF);
    rd_chk("R3/R7 all-ones write", 1, 16'h0678);
    rd_chk("R10 other channel untouched", 0, 16'h0000);
    // R4: end on source only for channel 0
    wr(0, 16'h0020);
    idle(); src_ph = 3'b001; last_xfer = 3'b000; #1;
    chk("R4 no end without last", 32'(end_pulse[0]), 32'h0);
    cycle();
    idle(); src_ph = 3'b001; last_xfer = 3'b001; #1;
    chk("R4 end on source", 32'(end_pulse[0]), 32'h1);
    cycle();
    idle(); dst_ph = 3'b001; last_xfer = 3'b001; #1;
    chk("R4 no end on destination", 32'(end_pulse[0]), 32'h0);
    cycle();
    // R5: acknowledge on destination for channel 2, last irrelevant
    wr(2, 16'h0010);
    idle(); dst_ph = 3'b100; #1;
    chk("R5 ack on destination", 32'(ack_pulse[2]), 32'h1);
    cycle();
    // R6, R8: done event then enable
    idle(); done_evt = 3'b001; cycle(); idle();
    rd_chk("R6 done flag", 0, 16'h0021);
    chk("R8 irq gated off", 32'(end_irq[0]), 32'h0);
    wr(0, 16'h0221);
    chk("R8 irq raised", 32'(end_irq[0]), 32'h1);
    idle(); err_evt = 3'b001; cycle(); idle();
    rd_chk("R6 overrun flag", 0, 16'h0227);
    wr(0, 16'h0220);
    chk("R8 irq drops on clear", 32'(end_irq[0]), 32'h0);
    // R9: error enable and flag
    wr(1, 16'h0400);
    idle(); err_evt = 3'b010; cycle(); idle();
    chk("R9 err irq", 32'(err_irq[1]), 32'h1);
    wr(1, 16'h0002);
    chk("R9 err irq drops on enable off", 32'(err_irq[1]), 32'h0);
    // R11: clearing write plus event same cycle
    idle(); reg_we = 1; reg_ch = 2'd1; reg_wdata = 16'h0400; done_evt = 3'b010;
    cycle(); idle();
    rd_chk("R11 event kept over clear", 1, 16'h0401);
    // R10: out-of-range channel
    wr(3, 16'h0678);
    rd_chk("R10 out-of-range read", 3, 16'h0000);
    rd_chk("R10 channel 2 kept", 2, 16'h0010);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      reg_we    = ($urandom % 6) == 0;
      reg_ch    = 2'($urandom % 4);
      reg_wdata = 16'($urandom);
      if ($urandom % 2) reg_wdata[2:0] = 3'b000;
      src_ph    = 3'($urandom);
      dst_ph    = 3'($urandom);
      last_xfer = 3'($urandom);
      done_evt  = 3'($urandom) & 3'($urandom) & 3'($urandom);
      err_evt   = 3'($urandom) & 3'($urandom) & 3'($urandom);
      cycle();
    end
    idle();
    for (int c = 0; c < 4; c++) rd_chk("R2/R6 final word", c, f_word(c));
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule